// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits between a synchronous system bus and a bank of byte-wide asynchronous EPROMs that share one data bus. A read request carries a device index in its upper address bits and a byte offset in its lower bits. The controller drives the offset onto the memory address lines and pulls low the chip select of the addressed device. It holds the shared output-enable strobe off until the latest point that still meets the access time. Once every access delay has elapsed, it samples the byte and returns it with a one-cycle pulse.

Both strobes are released on the capture edge, because the memory guarantees no output hold time. The controller then refuses new work until the output-float time has passed, so that no other device can start driving while the previous one is still on the bus. All delays are stored as nanosecond values for each speed grade. They are turned into whole clock cycles, rounded up, from a clock-period parameter. The request side is valid/ready: a request is taken on any edge where `req_valid` and `req_ready` are both high. A requester that sees `req_ready` low must hold its request and try again later. The response has no back-pressure: `rsp_valid` is a single-cycle pulse that the consumer must take.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, and whenever no read is in progress, every `mem_ce_n` bit and `mem_oe_n` are high, `rsp_valid` is low and `req_ready` is high.
- R2: On an accepted request, device index d is `req_addr[top DEV_W bits]` and the offset is `req_addr[MEM_AW-1:0]`. In the cycle after the accepting edge, `mem_ce_n` bit d is low, all other bits are high, and `mem_addr` equals the offset.
- R3: While a chip select stays low, `mem_addr` and `mem_ce_n` do not change.
- R4: `mem_oe_n` falls exactly LEAD = ACC - OE cycles after the chip select falls, where ACC and OE are the cycle counts of the access and output-enable delays.
- R5: The byte on `mem_data` is sampled on the edge where the chip select has been low for ACC cycles and the output enable for OE cycles. It appears on `rsp_data` while `rsp_valid` is high, and `rsp_valid` lasts exactly one cycle.
- R6: In the cycle `rsp_valid` is high, all chip selects and the output enable are already high.
- R7: `req_ready` is low from the accepting edge until DF - 1 cycles after the strobes are released. The earliest next chip select therefore falls exactly DF cycles after the release, where DF is the float-time cycle count.
- R8: For each delay, the cycle count is ceil(ns / CLK_PERIOD_NS). The nanosecond values come from `SPEED_GRADE`: grade 0 = 120/60/40, grade 1 = 150/65/50, grade 2 = 200/70/60, grade 3 = 250/100/60 (access/output-enable/float).
- R9: A request presented while `req_ready` is low is not accepted: it changes neither the strobes, the address nor the returned byte.
- R10: `mem_oe_n` is never low unless some chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | DEV_W+MEM_AW | Device index (upper bits) and byte offset |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the read byte |
| rsp_data | output | DATA_W | Captured byte |
| mem_addr | output | MEM_AW | Memory address lines |
| mem_ce_n | output | NDEV | Active-low chip select, one per device |
| mem_oe_n | output | 1 | Active-low output enable, shared by all devices |
| mem_data | input | DATA_W | Shared memory data bus |

## Verification
The hardest case to bring about is a request arriving in the very cycle the float gap expires, right after a completed read. It is the only situation that shows whether the gap is exactly DF cycles rather than merely long enough. The bench reaches it by keeping `req_valid` high through the whole access and float period. First it holds a different "junk" address, to show that this pending request is ignored. Two cycles before the gap ends, it swaps in the next real request, so acceptance happens on the first permitted edge. The memory model returns a wrong byte whenever the strobes have not yet been low long enough, so a capture even one cycle early shows up as wrong data.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ACCESS = 2'd1,
    SEQ_FLOAT  = 2'd2
  } seq_state_t;

  // Address-to-data and select-to-data time per grade (ns)
  function automatic int grade_acc_ns(input int grade);
    case (grade)
      0:       return 120;
      1:       return 150;
      2:       return 200;
      default: return 250;
    endcase
  endfunction

  // Output-enable-to-data time per grade (ns)
  function automatic int grade_oe_ns(input int grade);
    case (grade)
      0:       return 60;
      1:       return 65;
      2:       return 70;
      default: return 100;
    endcase
  endfunction

  // Strobe release to bus float time per grade (ns), worst case
  function automatic int grade_df_ns(input int grade);
    case (grade)
      0:       return 40;
      1:       return 50;
      default: return 60;
    endcase
  endfunction

  // Round a delay up to whole clock cycles, never below one
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/eprom_delay_cnt.sv
module eprom_delay_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/eprom_ce_decode.sv
module eprom_ce_decode #(
  parameter int NDEV  = 4,
  parameter int DEV_W = 2
) (
  input  logic [DEV_W-1:0] sel,
  input  logic             en,
  output logic [NDEV-1:0]  ce_n
);

  for (genvar i = 0; i < NDEV; i++) begin : g_sel
    assign ce_n[i] = !(en && (sel == DEV_W'(i)));
  end

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
  import eprom_rd_pkg::*;
#(
  parameter int ACC_CYC  = 15,
  parameter int LEAD_CYC = 7,
  parameter int DF_CYC   = 5,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             accept,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             ce_on_nx,
  output logic             oe_on_nx,
  output logic             capture
);

  seq_state_t st, nxt;
  logic       gap_done;

  assign gap_done  = (st == SEQ_FLOAT) && (cnt == CNT_W'(DF_CYC - 1));
  assign req_ready = (st == SEQ_IDLE) || gap_done;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt      = st;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    ce_on_nx = 1'b0;
    oe_on_nx = 1'b0;
    capture  = 1'b0;
    unique case (st)
      SEQ_IDLE: ;
      SEQ_ACCESS: begin
        if (cnt == CNT_W'(ACC_CYC - 1)) begin
          // Sample and release together: the device has no hold time
          capture = 1'b1;
          cnt_clr = 1'b1;
          nxt     = SEQ_FLOAT;
        end else begin
          cnt_inc  = 1'b1;
          ce_on_nx = 1'b1;
          oe_on_nx = (int'(cnt) + 1 >= LEAD_CYC);
        end
      end
      SEQ_FLOAT: begin
        if (gap_done) nxt = SEQ_IDLE;
        else          cnt_inc = 1'b1;
      end
      default: nxt = SEQ_IDLE;
    endcase
    if (accept) begin
      nxt      = SEQ_ACCESS;
      cnt_clr  = 1'b1;
      cnt_inc  = 1'b0;
      ce_on_nx = 1'b1;
      oe_on_nx = (LEAD_CYC == 0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SEQ_IDLE;
    else        st <= nxt;
  end

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int NDEV          = 4,
  parameter int MEM_AW        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_GRADE   = 0,
  localparam int DEV_W        = $clog2(NDEV)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [DEV_W+MEM_AW-1:0] req_addr,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_data,
  output logic [MEM_AW-1:0]       mem_addr,
  output logic [NDEV-1:0]         mem_ce_n,
  output logic                    mem_oe_n,
  input  logic [DATA_W-1:0]       mem_data
);

  localparam int ACC_CYC  = ns_to_cycles(grade_acc_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int OE_CYC   = ns_to_cycles(grade_oe_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int DF_CYC   = ns_to_cycles(grade_df_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int LEAD_CYC = ACC_CYC - OE_CYC;
  localparam int MAX_CYC  = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic             accept, cnt_clr, cnt_inc, ce_on_nx, oe_on_nx, capture;
  logic [CNT_W-1:0] cnt;
  logic [DEV_W-1:0] dev_q, dev_nx;
  logic [NDEV-1:0]  ce_n_nx;
  logic [MEM_AW-1:0] addr_q;
  logic [NDEV-1:0]  ce_n_q;
  logic             oe_n_q;
  logic             rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  eprom_rd_seq #(
    .ACC_CYC (ACC_CYC),
    .LEAD_CYC(LEAD_CYC),
    .DF_CYC  (DF_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .accept   (accept),
    .cnt      (cnt),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .ce_on_nx (ce_on_nx),
    .oe_on_nx (oe_on_nx),
    .capture  (capture)
  );

  eprom_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .cnt  (cnt)
  );

  assign dev_nx = accept ? req_addr[DEV_W+MEM_AW-1:MEM_AW] : dev_q;

  eprom_ce_decode #(.NDEV(NDEV), .DEV_W(DEV_W)) u_dec (
    .sel (dev_nx),
    .en  (ce_on_nx),
    .ce_n(ce_n_nx)
  );

  // All pin-facing strobes come straight from flops
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_q       <= '0;
      addr_q      <= '0;
      ce_n_q      <= '1;
      oe_n_q      <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      dev_q       <= dev_nx;
      if (accept) addr_q <= req_addr[MEM_AW-1:0];
      ce_n_q      <= ce_n_nx;
      oe_n_q      <= !oe_on_nx;
      rsp_valid_q <= capture;
      if (capture) rsp_data_q <= mem_data;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_oe_n  = oe_n_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
module eprom_rd_ctrl_chk
  import eprom_rd_pkg::*;
#(
  parameter int NDEV          = 4,
  parameter int MEM_AW        = 17,
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_GRADE   = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [NDEV-1:0]   mem_ce_n,
  input logic              mem_oe_n
);

  localparam int ACC_CYC  = ns_to_cycles(grade_acc_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int OE_CYC   = ns_to_cycles(grade_oe_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int DF_CYC   = ns_to_cycles(grade_df_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int LEAD_CYC = ACC_CYC - OE_CYC;
  localparam int SAT      = 4096;

  logic all_hi;
  int   ce_lo_cnt, oe_lo_cnt, hi_cnt;

  assign all_hi = &mem_ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_lo_cnt <= 0;
      oe_lo_cnt <= 0;
      hi_cnt    <= SAT;
    end else begin
      ce_lo_cnt <= all_hi   ? 0 : ((ce_lo_cnt < SAT) ? ce_lo_cnt + 1 : SAT);
      oe_lo_cnt <= mem_oe_n ? 0 : ((oe_lo_cnt < SAT) ? oe_lo_cnt + 1 : SAT);
      hi_cnt    <= !all_hi  ? 0 : ((hi_cnt < SAT) ? hi_cnt + 1 : SAT);
    end
  end

  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n)); // R2

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_hi && !$past(all_hi)) |-> ($stable(mem_addr) && $stable(mem_ce_n))); // R3

  AST_OE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (ce_lo_cnt == LEAD_CYC)); // R4

  AST_CAPTURE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ce_lo_cnt >= ACC_CYC && oe_lo_cnt >= OE_CYC)); // R5

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5

  AST_RELEASE_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (all_hi && mem_oe_n)); // R6

  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && all_hi) |-> (hi_cnt >= DF_CYC - 1)); // R7

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !all_hi); // R10

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
  .NDEV         (NDEV),
  .MEM_AW       (MEM_AW),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .SPEED_GRADE  (SPEED_GRADE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_addr (mem_addr),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n)
);

// File: tb/tb_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module tb_eprom_rd_ctrl;

  localparam int NDEV   = 4;
  localparam int DEV_W  = 2;
  localparam int MEM_AW = 17;
  localparam int DATA_W = 8;
  localparam int PER    = 8;
  localparam int GRADE  = 0;

  // Expected cycle counts, derived from R8
  localparam int ACC_NS = (GRADE == 0) ? 120 : (GRADE == 1) ? 150 : (GRADE == 2) ? 200 : 250;
  localparam int OE_NS  = (GRADE == 0) ? 60  : (GRADE == 1) ? 65  : (GRADE == 2) ? 70  : 100;
  localparam int DF_NS  = (GRADE == 0) ? 40  : (GRADE == 1) ? 50  : 60;
  localparam int ACC    = (ACC_NS + PER - 1) / PER;
  localparam int OE     = (OE_NS + PER - 1) / PER;
  localparam int DF     = (DF_NS + PER - 1) / PER;
  localparam int LEAD   = ACC - OE;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic [DEV_W+MEM_AW-1:0] req_addr = '0;
  logic                    rsp_valid;
  logic [DATA_W-1:0]       rsp_data;
  logic [MEM_AW-1:0]       mem_addr;
  logic [NDEV-1:0]         mem_ce_n;
  logic                    mem_oe_n;
  logic [DATA_W-1:0]       mem_data;

  int checks = 0;
  int failures = 0;
  int oe_wo_ce = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eprom_rd_ctrl #(
    .NDEV(NDEV), .MEM_AW(MEM_AW), .DATA_W(DATA_W),
    .CLK_PERIOD_NS(PER), .SPEED_GRADE(GRADE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_data(mem_data)
  );

  function automatic logic [7:0] exp_byte(input int dev, input logic [MEM_AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'(dev * 37 + 1);
  endfunction

  // Memory model: a correct byte only once both strobes have been low long enough
  int ce_k = 0, oe_k = 0;
  always @(posedge clk) begin
    ce_k <= (&mem_ce_n) ? 0 : ce_k + 1;
    oe_k <= mem_oe_n ? 0 : oe_k + 1;
    if (rst_n && !mem_oe_n && (&mem_ce_n)) oe_wo_ce <= oe_wo_ce + 1;
  end

  always_comb begin
    int sel;
    sel = -1;
    for (int i = 0; i < NDEV; i++) if (!mem_ce_n[i]) sel = i;
    if (sel >= 0 && !mem_oe_n && (ce_k + 1 >= ACC) && (oe_k + 1 >= OE))
      mem_data = exp_byte(sel, mem_addr);
    else
      mem_data = ~exp_byte((sel < 0) ? 0 : sel, mem_addr);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One read; if chain, the next request is presented so it lands on the first allowed edge
  task automatic do_read(input int dev, input logic [MEM_AW-1:0] low, input bit chain,
                         input int ndev, input logic [MEM_AW-1:0] nlow);
    int oe_first, rsp_at, pulses, moved, ready_bad, junk_hit, last_n;
    bit released, ready_ok;
    logic [7:0] got;
    logic [NDEV-1:0] ce_exp;
    oe_first = -1; rsp_at = -1; pulses = 0; moved = 0; ready_bad = 0; junk_hit = 0;
    released = 0; ready_ok = 0; got = '0;
    ce_exp = ~(NDEV'(1) << dev);
    req_valid = 1'b1;
    req_addr  = {DEV_W'(dev), low};
    @(negedge clk);
    check(mem_ce_n == ce_exp, "R2 chip select", int'(mem_ce_n), int'(ce_exp));
    check(mem_addr == low, "R2 address", int'(mem_addr), int'(low));
    check(req_ready == 1'b0, "R7 ready after accept", int'(req_ready), 0);
    if (!mem_oe_n) oe_first = 0;
    // Junk request held during access and float (R9)
    req_addr = {DEV_W'(dev ^ 1), ~low};
    last_n = chain ? ACC + DF - 1 : ACC + DF + 1;
    for (int n = 1; n <= last_n; n++) begin
      @(negedge clk);
      if (n < ACC && (mem_ce_n != ce_exp || mem_addr != low)) moved++;
      if (!mem_oe_n && oe_first < 0) oe_first = n;
      if (rsp_valid) begin
        pulses++;
        if (rsp_at < 0) begin rsp_at = n; got = rsp_data; end
      end
      if (n == ACC) released = (&mem_ce_n) && mem_oe_n;
      if (n > ACC && !(&mem_ce_n)) junk_hit++;
      if (n <= ACC + DF - 2 && req_ready) ready_bad++;
      if (n == ACC + DF - 1) ready_ok = req_ready;
      if (n == ACC + DF - 2) begin
        if (chain) req_addr = {DEV_W'(ndev), nlow};
        else       req_valid = 1'b0;
      end
    end
    check(moved == 0, "R3 address/select stable", moved, 0);
    check(oe_first == LEAD, "R4 output enable lead", oe_first, LEAD);
    check(rsp_at == ACC, "R8 access cycles", rsp_at, ACC);
    check(got == exp_byte(dev, low), "R5 data", int'(got), int'(exp_byte(dev, low)));
    check(pulses == 1, "R5 single pulse", pulses, 1);
    check(released, "R6 strobes released", int'(released), 1);
    check(ready_bad == 0 && ready_ok, "R7 float gap ready", ready_bad, 0);
    check(junk_hit == 0, "R9 request ignored while busy", junk_hit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(&mem_ce_n, "R1 reset chip selects", int'(mem_ce_n), (1 << NDEV) - 1);
    check(mem_oe_n == 1'b1, "R1 reset output enable", int'(mem_oe_n), 1);
    check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 reset response", int'(rsp_valid), 0);

    // Sweep every device with several offsets; most reads chained back to back
    for (int j = 0; j < 24; j++) begin
      int dev, ndev;
      logic [MEM_AW-1:0] low, nlow;
      dev  = j % NDEV;
      ndev = (j + 1) % NDEV;
      low  = (j % 6 == 0) ? '0 : (j % 6 == 1) ? '1 : MEM_AW'(j * 12345 + 777);
      nlow = ((j + 1) % 6 == 0) ? '0 : ((j + 1) % 6 == 1) ? '1 : MEM_AW'((j + 1) * 12345 + 777);
      do_read(dev, low, (j % 3 != 2) && (j != 23), ndev, nlow);
    end

    // Idle: standby with no request
    repeat (10) @(negedge clk);
    check(&mem_ce_n && mem_oe_n && req_ready, "R1 idle standby", int'(mem_ce_n), (1 << NDEV) - 1);
    check(oe_wo_ce == 0, "R10 output enable without select", oe_wo_ce, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * PER);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule